// File: doc/BRIEF.md
# Oversampled 1-bit Audio Stream Front-End with Duty Shaping

This block takes a 1-bit, 64x oversampled audio stream and prepares it for a resistor-weighted, current-output FIR stage. A system clock runs four times faster than the data bit clock. The serial data and the bit clock are captured on the falling edge of the system clock. Each new bit is detected as a rising edge of the captured bit clock and is pushed into an eight-stage tap history.

From that history the block forms a "hot" copy and a complementary "cold" copy. A polarity input swaps the two copies. Each copy drives a positive tap group and a negative tap group, which gives four 8-bit tap vectors. Every tap is gated by a duty pulse that is active for three of the four system-clock slots of a data bit. This gives the analog network a 75% duty waveform that returns to zero once per bit.

An active-low synchronous reset parks the taps at a balanced bipolar-zero pattern. In that pattern the summed differential current of the four groups is zero.

Top module: `dsd_frontend`

## Requirements
- R1: `bclk` and `sdata` are captured on the falling edge of `clk`. A new bit is taken when the captured `bclk` is high and was low at the previous rising edge. That bit enters tap 0, and tap i then holds the bit received i bit-edges earlier. The change is visible after the rising edge that detects the bit.
- R2: The rising edge that takes a bit sets the slot to 0, and each later rising edge advances it by one. In slots 0, 1 and 2 the duty gate is open. In slot 3 all four tap vectors are 0.
- R3: For every tap and each line, the positive output is the line bit ANDed with the duty gate. The negative output is the inverted line bit ANDed with the duty gate. A positive output and its negative partner are never both 1.
- R4: `pol_inv` is sampled on the rising edge of `clk` and applies from the next edge onward. With `pol_inv`=0 the hot line equals the received bits and the cold line is their inverse. With `pol_inv`=1 the two lines are swapped.
- R5: At all times `cold_pos` equals `hot_neg` and `cold_neg` equals `hot_pos`.
- R6: `rst_n` is active low and sampled on the rising edge. One edge after it is seen low, and for as long as it stays low, the outputs are as follows: `hot_pos`=8'h55 (hot tap i is 1 for even i), `hot_neg`=8'hAA, `cold_pos`=8'hAA, `cold_neg`=8'h55. This holds whatever `pol_inv` is.
- R7: After reset is released, the taps keep the bipolar-zero history (bit i = 1 for even i) and shift it out as new bits arrive.
- R8: A bit-clock rising edge that is detected while reset is low is discarded and never enters the history.
- R9: A `pol_inv` change that is sampled on the same edge as a bit edge makes the new bit and the older taps appear with the new polarity in slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four periods per data bit |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising edge |
| bclk | input | 1 | Data bit clock, sampled on falling edge of `clk` |
| sdata | input | 1 | Serial 1-bit data, sampled on falling edge of `clk` |
| pol_inv | input | 1 | Polarity select: 0 normal, 1 hot and cold swapped |
| hot_pos | output | TAPS (8) | Hot line taps, positive group, duty gated |
| hot_neg | output | TAPS (8) | Hot line taps, negative group, duty gated |
| cold_pos | output | TAPS (8) | Cold line taps, positive group, duty gated |
| cold_neg | output | TAPS (8) | Cold line taps, negative group, duty gated |

## Verification
Two pairs of events are made to fall on the same rising edge. In the first pair, a polarity toggle is driven in slot 3 so that it is sampled on the very edge that takes the next bit. The slot-0 outputs must then show both the shifted history and the new polarity at once. In the second pair, reset is pulled low together with a rising bit clock. The outputs must stay at the balanced pattern, and the bits that follow release must shift in behind the untouched bipolar-zero history rather than behind the discarded bit. All 256 byte patterns are streamed, with the polarity flipped in varying slots, and every slot of every bit is compared with a history model kept in the bench.

// File: rtl/dsd_fe_pkg.sv
// Shared definitions for the stream front-end.
// Assumes: the balanced reset pattern sets even-numbered taps to 1.
package dsd_fe_pkg;

    typedef enum logic {
        POL_NORMAL  = 1'b0,
        POL_SWAPPED = 1'b1
    } pol_e;

    // Returns the balanced history pattern for a given width (even taps high).
    function automatic logic [63:0] balanced_pattern(input int unsigned width);
        logic [63:0] p;
        p = '0;
        for (int unsigned i = 0; i < width && i < 64; i++) begin
            p[i] = ((i % 2) == 0);
        end
        return p;
    endfunction

endpackage

// File: rtl/dsd_fe_sampler.sv
// Captures serial data and bit clock on the falling system-clock edge and
// flags a new bit on the rising system-clock edge.
// Assumes: inputs are stable around the falling edge of clk.
module dsd_fe_sampler (
    input  logic clk,
    input  logic bclk,
    input  logic sdata,
    output logic bit_edge,
    output logic bit_val
);
    logic bclk_s;
    logic data_s;
    logic bclk_d;

    // Falling-edge capture of the stream inputs.
    always_ff @(negedge clk) begin
        bclk_s <= bclk;
        data_s <= sdata;
    end

    // Rising-edge copy of the captured bit clock for edge detection.
    always_ff @(posedge clk) begin
        bclk_d <= bclk_s;
    end

    assign bit_edge = bclk_s & ~bclk_d;
    assign bit_val  = data_s;
endmodule

// File: rtl/dsd_fe_slot_ctr.sv
// Tracks the system-clock slot inside one data bit and produces the duty gate.
// Assumes: a bit edge arrives every SLOTS clocks; otherwise it wraps freely.
module dsd_fe_slot_ctr #(
    parameter int unsigned SLOTS  = 4,
    parameter int unsigned ACTIVE = 3,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_edge,
    output logic [SLOT_W-1:0] slot_q,
    output logic              duty_on
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] ACT_LIM   = SLOT_W'(ACTIVE);

    // Slot counter: cleared by reset or a new bit, wraps after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || bit_edge) begin
            slot_q <= '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign duty_on = (slot_q < ACT_LIM);
endmodule

// File: rtl/dsd_fe_tap_line.sv
// Tap history of received bits; tap 0 holds the newest bit.
// Assumes: reset loads the balanced pattern and overrides a coincident bit.
module dsd_fe_tap_line
    import dsd_fe_pkg::*;
#(
    parameter int unsigned TAPS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_edge,
    input  logic            bit_val,
    output logic [TAPS-1:0] line_q
);
    localparam logic [63:0]     PAT64 = balanced_pattern(TAPS);
    localparam logic [TAPS-1:0] BPZ   = PAT64[TAPS-1:0];

    // Shift register: reset to balanced pattern, shift on each new bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= BPZ;
        end else if (bit_edge) begin
            line_q <= {line_q[TAPS-2:0], bit_val};
        end
    end
endmodule

// File: rtl/dsd_fe_shaper.sv
// Registers polarity, forms hot and cold copies and gates every tap with the
// duty pulse into positive and negative groups.
// Assumes: polarity register resets to normal.
module dsd_fe_shaper
    import dsd_fe_pkg::*;
#(
    parameter int unsigned TAPS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pol_inv,
    input  logic            duty_on,
    input  logic [TAPS-1:0] line_q,
    output logic [TAPS-1:0] hot_pos,
    output logic [TAPS-1:0] hot_neg,
    output logic [TAPS-1:0] cold_pos,
    output logic [TAPS-1:0] cold_neg
);
    pol_e pol_q;

    // Polarity register, sampled on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= POL_NORMAL;
        end else begin
            pol_q <= pol_e'(pol_inv);
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        logic hot_bit;
        logic cold_bit;
        // Per-tap copy forming and duty gating.
        always_comb begin
            hot_bit     = (pol_q == POL_SWAPPED) ? ~line_q[i] : line_q[i];
            cold_bit    = ~hot_bit;
            hot_pos[i]  = hot_bit & duty_on;
            hot_neg[i]  = ~hot_bit & duty_on;
            cold_pos[i] = cold_bit & duty_on;
            cold_neg[i] = ~cold_bit & duty_on;
        end
    end
endmodule

// File: rtl/dsd_frontend.sv
// Top of the stream front-end: sampler, slot counter, tap history, shaper.
// Assumes: bclk period equals SLOTS system clocks.
module dsd_frontend #(
    parameter int unsigned TAPS   = 8,
    parameter int unsigned SLOTS  = 4,
    parameter int unsigned ACTIVE = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk,
    input  logic            sdata,
    input  logic            pol_inv,
    output logic [TAPS-1:0] hot_pos,
    output logic [TAPS-1:0] hot_neg,
    output logic [TAPS-1:0] cold_pos,
    output logic [TAPS-1:0] cold_neg
);
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic              bit_edge;
    logic              bit_val;
    logic [SLOT_W-1:0] slot_q;
    logic              duty_on;
    logic [TAPS-1:0]   line_q;

    dsd_fe_sampler u_sampler (
        .clk      (clk),
        .bclk     (bclk),
        .sdata    (sdata),
        .bit_edge (bit_edge),
        .bit_val  (bit_val)
    );

    dsd_fe_slot_ctr #(.SLOTS(SLOTS), .ACTIVE(ACTIVE)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_edge (bit_edge),
        .slot_q   (slot_q),
        .duty_on  (duty_on)
    );

    dsd_fe_tap_line #(.TAPS(TAPS)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_edge (bit_edge),
        .bit_val  (bit_val),
        .line_q   (line_q)
    );

    dsd_fe_shaper #(.TAPS(TAPS)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .pol_inv  (pol_inv),
        .duty_on  (duty_on),
        .line_q   (line_q),
        .hot_pos  (hot_pos),
        .hot_neg  (hot_neg),
        .cold_pos (cold_pos),
        .cold_neg (cold_neg)
    );
endmodule

// File: rtl/dsd_frontend_chk.sv
// Property checker for the stream front-end, attached by bind.
module dsd_frontend_chk
    import dsd_fe_pkg::*;
#(
    parameter int unsigned TAPS   = 8,
    parameter int unsigned SLOT_W = 2,
    parameter int unsigned ACTIVE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_edge,
    input logic [SLOT_W-1:0] slot_q,
    input logic [TAPS-1:0]   hot_pos,
    input logic [TAPS-1:0]   hot_neg,
    input logic [TAPS-1:0]   cold_pos,
    input logic [TAPS-1:0]   cold_neg
);
    localparam logic [63:0]     PAT64 = balanced_pattern(TAPS);
    localparam logic [TAPS-1:0] BPZ   = PAT64[TAPS-1:0];

    logic armed = 1'b0;
    // Arms the properties after the first clock edge.
    always @(posedge clk) armed <= 1'b1;

    // R5
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (cold_pos == hot_neg) && (cold_neg == hot_pos));

    // R3
    pos_neg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (hot_pos & hot_neg) == '0);

    // R2
    quiet_slot_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (slot_q >= SLOT_W'(ACTIVE)) |->
        (hot_pos == '0 && hot_neg == '0 && cold_pos == '0 && cold_neg == '0));

    // R2
    edge_slot_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        bit_edge |=> (slot_q == '0));

    // R6
    reset_bpz_chk: assert property (@(posedge clk) disable iff (!armed)
        !rst_n |=> (hot_pos == BPZ && hot_neg == ~BPZ &&
                    cold_pos == ~BPZ && cold_neg == BPZ));
endmodule

bind dsd_frontend dsd_frontend_chk #(
    .TAPS   (TAPS),
    .SLOT_W (SLOT_W),
    .ACTIVE (ACTIVE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_edge (bit_edge),
    .slot_q   (slot_q),
    .hot_pos  (hot_pos),
    .hot_neg  (hot_neg),
    .cold_pos (cold_pos),
    .cold_neg (cold_neg)
);

// File: tb/dsd_frontend_bench.sv
// Self-checking bench: streams every byte pattern, flips polarity in varied
// slots, and collides reset and polarity with bit edges.
module dsd_frontend_bench;
    localparam int TAPS = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n   = 1'b0;
    logic bclk    = 1'b0;
    logic sdata   = 1'b0;
    logic pol_inv = 1'b0;
    logic [TAPS-1:0] hot_pos, hot_neg, cold_pos, cold_neg;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] hist = 8'h55;

    dsd_frontend u_dsd_frontend (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .sdata    (sdata),
        .pol_inv  (pol_inv),
        .hot_pos  (hot_pos),
        .hot_neg  (hot_neg),
        .cold_pos (cold_pos),
        .cold_neg (cold_neg)
    );

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected outputs from bench history, polarity input and slot number.
    task automatic check_slot(input string tag, input int s);
        logic [7:0] h;
        logic [7:0] g;
        h = hist ^ {8{pol_inv}};
        g = (s < 3) ? 8'hFF : 8'h00;
        cmp({tag, " hot_pos"},  hot_pos,  h & g);
        cmp({tag, " hot_neg"},  hot_neg,  ~h & g);
        cmp({tag, " cold_pos"}, cold_pos, ~h & g);
        cmp({tag, " cold_neg"}, cold_neg, h & g);
    endtask

    task automatic check_bpz(input string tag);
        cmp({tag, " hot_pos"},  hot_pos,  8'h55);
        cmp({tag, " hot_neg"},  hot_neg,  8'hAA);
        cmp({tag, " cold_pos"}, cold_pos, 8'hAA);
        cmp({tag, " cold_neg"}, cold_neg, 8'h55);
    endtask

    // Called 2 ns after a rising edge; returns 2 ns after the fourth edge.
    task automatic send_bit(input logic b, input int flip_at, input string tag);
        bclk  = 1'b1;
        sdata = b;
        hist  = {hist[6:0], b};
        for (int s = 0; s < 4; s++) begin
            @(posedge clk);
            #2;
            check_slot(tag, s);
            if (s == 1) bclk = 1'b0;
            if (s == flip_at) pol_inv = ~pol_inv;
        end
    endtask

    // Holds reset for three edges, optionally with a colliding bit edge.
    task automatic reset_hold(input bit with_edge, input string tag);
        rst_n = 1'b0;
        if (with_edge) begin
            bclk  = 1'b1;
            sdata = ~hist[0];
        end
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #2;
            check_bpz(tag);
            bclk = 1'b0;
        end
        rst_n = 1'b1;
        hist  = 8'h55;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check_bpz("R6 reset state");
        rst_n = 1'b1;
        // R7: the first bits shift in behind the balanced history.
        send_bit(1'b0, 9, "R7 post-reset");
        send_bit(1'b0, 9, "R7 post-reset");
        // R1 R2 R3 R4 R5: exhaustive byte sweep, polarity flipped in varied slots.
        for (int pat = 0; pat < 256; pat++) begin
            for (int i = 7; i >= 0; i--) begin
                int fa;
                fa = ((pat + i) % 11 < 4) ? (pat + i) % 11 : 9;
                send_bit(pat[i], fa, (fa == 3) ? "R9 pol+edge" : "R1 R2 R3 R4 R5 sweep");
            end
        end
        // R9: polarity toggle sampled on the same edge as the next bit.
        for (int k = 0; k < 6; k++) send_bit(k[0], 3, "R9 pol+edge");
        // R6: reset with polarity input high still yields the balanced pattern.
        pol_inv = 1'b1;
        reset_hold(1'b0, "R6 reset pol high");
        for (int k = 0; k < 5; k++) send_bit(k[1], 9, "R7 history after reset");
        // R8: bit edge coinciding with reset is discarded.
        reset_hold(1'b1, "R8 reset+edge");
        for (int k = 0; k < 9; k++) send_bit(1'b1, 9, "R8 no stale bit");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule